// File: doc/BRIEF.md
# Fault-Injectable Register File

This block is a processor register file of WIDTH-bit entries, 135 entries deep by default. That depth is enough to hold a windowed register set flattened into one linear array. The CPU side has two combinational read ports and one synchronous write port. A fault-injection controller has a port pair of its own beside them. A read port returns the entry named by the injection address. A one-cycle strobe flips the bits of that entry selected by a mask. The flip lands in one clock edge and never stalls the CPU.

The flip is a masked read-modify-write of a single entry. It normally acts on the stored contents. If the CPU writes the same entry in the same cycle, the flip acts on the incoming CPU data instead, so the injected upset always survives. The controller can read the target before and after the flip through its own read port to log the effect.

Top module: `fi_regfile`

## Requirements
- R1: A synchronous active-high reset clears every entry to zero, so every read port returns zero in the cycle after reset.
- R2: A CPU write (wr_en high, wr_addr below DEPTH) stores wr_data at the clock edge. Both CPU read ports return it from the next cycle on.
- R3: CPU reads have no write bypass: in the cycle of a write, a read of the written entry returns the previous contents.
- R4: With inj_stb high and no CPU write to the same entry, the entry at inj_addr becomes its stored value XOR inj_mask after the edge. A CPU write to a different entry in that cycle completes normally.
- R5: With inj_stb high and a CPU write to the same entry in the same cycle, the entry becomes wr_data XOR inj_mask. A zero mask therefore leaves a plain CPU write.
- R6: inj_rdata combinationally returns the entry at inj_addr, both before the flip and in the cycle after it.
- R7: In the injection cycle itself, the CPU read ports and inj_rdata return the value from before the injection.
- R8: Addresses at or above DEPTH select nothing: writes and injections to them change no entry, and reads of them return zero.
- R9: While inj_stb is low, inj_mask and inj_addr change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_addr | input | AW | CPU read port A address (AW = ceil(log2 DEPTH)) |
| rd_a_data | output | WIDTH | CPU read port A data |
| rd_b_addr | input | AW | CPU read port B address |
| rd_b_data | output | WIDTH | CPU read port B data |
| wr_en | input | 1 | CPU write enable |
| wr_addr | input | AW | CPU write address |
| wr_data | input | WIDTH | CPU write data |
| inj_stb | input | 1 | One-cycle injection strobe |
| inj_addr | input | AW | Injection target address (read and write) |
| inj_mask | input | WIDTH | Bits to flip, 1 = flip |
| inj_rdata | output | WIDTH | Entry at inj_addr, combinational |

## Verification
The bench uses a 10-entry, 16-bit configuration and flips every bit of every entry one at a time. In each of those cycles it also makes a CPU write to the neighbouring entry. Each flip is checked in two places: against the pre-injection value seen in the strike cycle, and against the flipped value one cycle later. This separates a correct flip from a missing flip, a wrong bit, an early flip and a flip that blocks a neighbour's write. Collisions are swept with zero, full, edge-bit and single-bit masks, which distinguishes "CPU data XOR mask" from "stored data XOR mask" and from a dropped CPU write. A separate pass holds the strobe low while a full mask is presented. Another drives the unused addresses above DEPTH and expects no entry to change and zero on every read.

// File: rtl/fi_rf_pkg.sv
package fi_rf_pkg;

    localparam int unsigned RF_DEPTH_DEFAULT = 135;
    localparam int unsigned RF_WIDTH_DEFAULT = 32;

    // What an entry does at the next edge
    typedef enum logic [1:0] {
        OP_HOLD      = 2'd0,
        OP_CPU_WRITE = 2'd1,
        OP_FLIP      = 2'd2
    } entry_op_e;

    // Which value the flip is applied to
    typedef enum logic {
        FLIP_ON_STORED = 1'b0,
        FLIP_ON_CPU    = 1'b1
    } flip_src_e;

    // Injection wins over a colliding CPU write
    function automatic entry_op_e pick_op(input logic cpu_hit, input logic inj_hit);
        if (inj_hit)      return OP_FLIP;
        else if (cpu_hit) return OP_CPU_WRITE;
        else              return OP_HOLD;
    endfunction

    // A colliding CPU write supplies the value that gets corrupted
    function automatic flip_src_e pick_src(input logic cpu_hit);
        return cpu_hit ? FLIP_ON_CPU : FLIP_ON_STORED;
    endfunction

endpackage

// File: rtl/fi_rf_decode.sv
module fi_rf_decode #(
    parameter int unsigned DEPTH = 135,
    parameter int unsigned AW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [AW-1:0]    addr,
    output logic [DEPTH-1:0] hit
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit[i] = en && (addr == AW'(i));
    end

    // R2 / R8: one request reaches at most one entry
    assert_single_target_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

endmodule

// File: rtl/fi_rf_entry.sv
module fi_rf_entry
    import fi_rf_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_hit,
    input  logic             inj_hit,
    input  logic [WIDTH-1:0] cpu_wdata,
    input  logic [WIDTH-1:0] inj_mask,
    output logic [WIDTH-1:0] q
);

    entry_op_e        op;
    flip_src_e        src;
    logic [WIDTH-1:0] base;
    logic [WIDTH-1:0] nxt;

    always_comb begin
        op   = pick_op(cpu_hit, inj_hit);
        src  = pick_src(cpu_hit);
        base = (src == FLIP_ON_CPU) ? cpu_wdata : q;
        unique case (op)
            OP_FLIP:      nxt = base ^ inj_mask;
            OP_CPU_WRITE: nxt = cpu_wdata;
            default:      nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/fi_rf_rdport.sv
module fi_rf_rdport #(
    parameter int unsigned DEPTH = 135,
    parameter int unsigned WIDTH = 32,
    parameter int unsigned AW    = 8
) (
    input  logic [DEPTH-1:0][WIDTH-1:0] store,
    input  logic [AW-1:0]               addr,
    output logic [WIDTH-1:0]            data
);

    // Addresses past DEPTH match no entry and read as zero
    always_comb begin
        data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr == AW'(i)) data = store[i];
        end
    end

endmodule

// File: rtl/fi_regfile.sv
module fi_regfile
    import fi_rf_pkg::*;
#(
    parameter  int unsigned DEPTH = RF_DEPTH_DEFAULT,
    parameter  int unsigned WIDTH = RF_WIDTH_DEFAULT,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_a_addr,
    output logic [WIDTH-1:0] rd_a_data,
    input  logic [AW-1:0]    rd_b_addr,
    output logic [WIDTH-1:0] rd_b_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             inj_stb,
    input  logic [AW-1:0]    inj_addr,
    input  logic [WIDTH-1:0] inj_mask,
    output logic [WIDTH-1:0] inj_rdata
);

    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic [DEPTH-1:0][WIDTH-1:0] store;
    logic [DEPTH-1:0]            cpu_hit;
    logic [DEPTH-1:0]            inj_hit;

    fi_rf_decode #(.DEPTH(DEPTH), .AW(AW)) u_wr_dec (
        .clk(clk), .rst(rst), .en(wr_en), .addr(wr_addr), .hit(cpu_hit)
    );

    fi_rf_decode #(.DEPTH(DEPTH), .AW(AW)) u_inj_dec (
        .clk(clk), .rst(rst), .en(inj_stb), .addr(inj_addr), .hit(inj_hit)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        fi_rf_entry #(.WIDTH(WIDTH)) u_entry (
            .clk(clk), .rst(rst),
            .cpu_hit(cpu_hit[i]), .inj_hit(inj_hit[i]),
            .cpu_wdata(wr_data), .inj_mask(inj_mask),
            .q(store[i])
        );
    end

    fi_rf_rdport #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_rd_a (
        .store(store), .addr(rd_a_addr), .data(rd_a_data)
    );

    fi_rf_rdport #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_rd_b (
        .store(store), .addr(rd_b_addr), .data(rd_b_data)
    );

    fi_rf_rdport #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_rd_inj (
        .store(store), .addr(inj_addr), .data(inj_rdata)
    );

    logic wr_ok, inj_ok, collide;
    assign wr_ok   = {1'b0, wr_addr}  < LIMIT;
    assign inj_ok  = {1'b0, inj_addr} < LIMIT;
    assign collide = wr_en && inj_stb && (wr_addr == inj_addr);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rd_a_data == '0 && rd_b_data == '0 && inj_rdata == '0));

    assert_cpu_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ok && !collide) |=> store[$past(wr_addr)] == $past(wr_data));

    assert_flip_stored_R4: assert property (@(posedge clk) disable iff (rst)
        (inj_stb && inj_ok && !collide) |=> store[$past(inj_addr)] == $past(inj_rdata ^ inj_mask));

    assert_flip_collide_R5: assert property (@(posedge clk) disable iff (rst)
        (collide && inj_ok) |=> store[$past(inj_addr)] == $past(wr_data ^ inj_mask));

    assert_range_read_R8: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, rd_a_addr} >= LIMIT) |-> rd_a_data == '0);

endmodule

// File: tb/tb_fi_regfile.sv
`timescale 1ns/1ps
module tb_fi_regfile;

    localparam int D  = 10;
    localparam int W  = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] rd_a_addr, rd_b_addr, wr_addr, inj_addr;
    logic [W-1:0]  rd_a_data, rd_b_data, wr_data, inj_mask, inj_rdata;
    logic          wr_en, inj_stb;

    logic [W-1:0]  mdl [D];
    int            checks = 0;
    int            errs   = 0;
    bit            done   = 0;

    fi_regfile #(.DEPTH(D), .WIDTH(W)) dut (
        .clk(clk), .rst(rst),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .inj_stb(inj_stb), .inj_addr(inj_addr), .inj_mask(inj_mask),
        .inj_rdata(inj_rdata)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; inj_stb = 1'b0; inj_mask = '0; wr_data = '0;
    endtask

    // One clock edge; the reference model follows the requirements
    task automatic tick();
        logic [W-1:0] flipped;
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < D; i++) mdl[i] = '0;
        end else begin
            flipped = '0;
            if (inj_stb && int'(inj_addr) < D)
                flipped = ((wr_en && wr_addr == inj_addr) ? wr_data : mdl[inj_addr]) ^ inj_mask;
            if (wr_en && int'(wr_addr) < D) mdl[wr_addr] = wr_data;
            if (inj_stb && int'(inj_addr) < D) mdl[inj_addr] = flipped;
        end
        @(negedge clk);
    endtask

    task automatic sweep_all(string req);
        idle();
        for (int a = 0; a < D; a++) begin
            rd_a_addr = AW'(a); rd_b_addr = AW'(D - 1 - a); inj_addr = AW'(a);
            #1;
            check(req, rd_a_data, mdl[a]);
            check(req, rd_b_data, mdl[D - 1 - a]);
            check(req, inj_rdata, mdl[a]);
        end
    endtask

    initial begin
        logic [W-1:0] masks [4];
        rst = 1'b1; idle();
        rd_a_addr = '0; rd_b_addr = '0; wr_addr = '0; inj_addr = '0;
        for (int i = 0; i < D; i++) mdl[i] = 'x;
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;

        // R1: everything reads zero after reset
        sweep_all("R1");

        // R3 during writes, R2 afterwards
        for (int a = 0; a < D; a++) begin
            wr_en = 1'b1; wr_addr = AW'(a); wr_data = W'(a * 16'h1357 + 16'h0a0b);
            rd_a_addr = AW'(a);
            #1 check("R3", rd_a_data, mdl[a]);
            tick();
        end
        sweep_all("R2");

        // R4 / R6 / R7: every bit of every entry, neighbour written meanwhile
        for (int a = 0; a < D; a++) begin
            for (int b = 0; b < W; b++) begin
                inj_stb = 1'b1; inj_addr = AW'(a); inj_mask = W'(1) << b;
                wr_en = 1'b1; wr_addr = AW'((a + 1) % D); wr_data = W'(a * 37 + b * 16'h0101);
                rd_a_addr = AW'(a); rd_b_addr = AW'((a + 1) % D);
                #1;
                check("R6", inj_rdata, mdl[a]);
                check("R7", rd_a_data, mdl[a]);
                tick();
                idle();
                #1;
                check("R4", rd_a_data, mdl[a]);
                check("R4", rd_b_data, mdl[(a + 1) % D]);
                check("R6", inj_rdata, mdl[a]);
            end
        end

        // R5: collisions with several masks, including zero
        for (int a = 0; a < D; a++) begin
            masks[0] = '0; masks[1] = '1; masks[2] = 16'h8001; masks[3] = W'(1) << a;
            for (int k = 0; k < 4; k++) begin
                wr_en = 1'b1; wr_addr = AW'(a); wr_data = W'(a * 16'h0f1 + k * 16'h3c00);
                inj_stb = 1'b1; inj_addr = AW'(a); inj_mask = masks[k];
                rd_a_addr = AW'(a);
                tick();
                idle();
                #1 check("R5", rd_a_data, mdl[a]);
            end
        end

        // R9: strobe low, full mask presented
        for (int a = 0; a < D; a++) begin
            idle(); inj_addr = AW'(a); inj_mask = '1; rd_a_addr = AW'(a);
            tick();
            #1 check("R9", rd_a_data, mdl[a]);
        end

        // R8: addresses past the depth
        for (int a = D; a < (1 << AW); a++) begin
            wr_en = 1'b1; wr_addr = AW'(a); wr_data = 16'hbeef;
            inj_stb = 1'b1; inj_addr = AW'(a); inj_mask = '1;
            rd_a_addr = AW'(a); rd_b_addr = AW'(a);
            #1;
            check("R8", rd_a_data, '0);
            check("R8", rd_b_data, '0);
            check("R8", inj_rdata, '0);
            tick();
        end
        sweep_all("R8");

        // R1 again: reset in mid-run clears the file
        rst = 1'b1; idle();
        tick();
        rst = 1'b0;
        sweep_all("R1");

        done = 1;
        summary();
        $finish;
    end

endmodule